// File: doc/BRIEF.md
# Download Command Packet Framer

This block sits on the host side of an in-circuit flash download link. It takes one command request at a time and turns it into a complete download packet on a byte stream that feeds an I2C master. A request is an opcode, a 32-bit target address and a payload length. The payload bytes are written beforehand into a small local buffer. While the packet goes out, the framer inserts a two-byte start marker and the count byte. It applies a bit rotation to verify payloads and appends a two's-complement checksum. The checksum is accumulated from the bytes as they leave, so the payload is read only once.

After the checksum byte the framer waits for the one-byte response that the I2C master reads back from the target. It then reports pass or fail for one cycle. Any negative response tells the host to abandon the download and start it again. Two kinds of request are refused without sending a single byte: a payload longer than 250 bytes, and a malformed erase request.

Top module: `dl_pkt_framer`

States: `ST_IDLE` (ready for a request), `ST_SYNC0` and `ST_SYNC1` (start marker), `ST_COUNT`, `ST_CMD`, `ST_ADDR` (four address bytes), `ST_DATA` (payload), `ST_SUM` (checksum), `ST_WAIT` (awaiting response), `ST_REPORT` (one-cycle result).

Transitions:
- `ST_IDLE` goes to `ST_SYNC0` when a valid request is accepted, or to `ST_REPORT` when the request is refused.
- Each send state advances on an output handshake: `ST_SYNC0` → `ST_SYNC1` → `ST_COUNT` → `ST_CMD` → `ST_ADDR`.
- `ST_ADDR` goes to `ST_DATA` after its last byte, or to `ST_SUM` if the payload is empty.
- `ST_DATA` goes to `ST_SUM` after the last payload byte.
- `ST_SUM` goes to `ST_WAIT` once the checksum byte is taken.
- `ST_WAIT` goes to `ST_REPORT` when a response byte arrives.
- `ST_REPORT` returns to `ST_IDLE`.

## Requirements
- R1: Each accepted packet leaves as 0x07, 0x0E, count, opcode, four address bytes with the most significant byte first, the payload bytes in buffer order (index 0 first), then the checksum.
- R2: The count byte equals the payload length plus 5.
- R3: The checksum byte equals 0x00 minus the 8-bit sum of the count, opcode, address and payload bytes, taken as transmitted.
- R4: When the opcode is 0x56 (verify), each payload byte b leaves as {b[4:0], b[7:5]}. For any other opcode the payload bytes leave unchanged.
- R5: A request with opcode 0x52 (run), address 0x00000001 and an empty payload leaves as 07 0E 05 52 00 00 00 01 A8.
- R6: An erase request (opcode 0x45) whose payload length is not exactly 1 (the page-count byte) is refused: no byte is emitted and the result reports reject.
- R7: A request whose payload length exceeds 250 is refused: no byte is emitted and the result reports reject. A length of exactly 250 is accepted and gives a count of 0xFF.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data is unchanged on the next cycle.
- R9: A response byte of 0x06 reports pass. Any other response byte, 0x07 included, reports fail with res_restart set. The response is taken only after the checksum byte has left.
- R10: req_ready is high only when no packet or response is pending. It is never high together with out_valid. res_valid lasts one cycle, with exactly one of res_pass, res_restart or res_reject set, and these flags are low whenever res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Payload buffer write strobe |
| buf_waddr | input | 8 | Payload buffer write index (0 to 249) |
| buf_wdata | input | 8 | Payload byte to store |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Framer is idle and takes the request |
| req_cmd | input | 8 | Opcode byte |
| req_addr | input | 32 | Target address |
| req_len | input | 9 | Payload length in bytes |
| out_valid | output | 1 | Packet byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Packet byte |
| rsp_valid | input | 1 | Response byte present |
| rsp_data | input | 8 | Response byte from the target |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Positive response received |
| res_restart | output | 1 | Negative response: download must restart |
| res_reject | output | 1 | Request refused without transmission |

## Verification
The assertions assume three things about the inputs:
- the payload buffer is not written while a packet is in flight;
- rsp_valid arrives only after the checksum byte has been taken;
- req_len stays within its 9-bit range.

The bench keeps to these assumptions in the following way:
- It loads the buffer only while req_ready is high.
- It raises rsp_valid for a single cycle, and only after its reference queue of expected bytes is empty and one further cycle has passed.
- It varies only out_ready between packets, choosing among always-ready and two stall patterns. These patterns put stalls on every kind of byte, the start marker, count, address, payload and checksum included.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC0,
        ST_SYNC1,
        ST_COUNT,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_SUM,
        ST_WAIT,
        ST_REPORT
    } fr_state_e;

    localparam logic [7:0] MARK_A    = 8'h07;
    localparam logic [7:0] MARK_B    = 8'h0E;
    localparam logic [7:0] RSP_OK    = 8'h06;
    localparam logic [7:0] OP_ERASE  = 8'h45;
    localparam logic [7:0] OP_VERIFY = 8'h56;

    // verify payload rearrangement: low five bits move up, high three move down
    function automatic logic [7:0] swizzle(input logic [7:0] b);
        return {b[4:0], b[7:5]};
    endfunction

endpackage

// File: rtl/dlf_payload_buf.sv
module dlf_payload_buf #(
    parameter int DEPTH = 250,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < (IDX_W+1)'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dlf_sum_acc.sv
module dlf_sum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       add_en,
    input  logic [7:0] add_byte,
    output logic [7:0] neg_sum
);
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_q <= 8'h00;
        end else if (add_en) begin
            sum_q <= sum_q + add_byte;
        end
    end

    assign neg_sum = 8'h00 - sum_q;
endmodule

// File: rtl/dlf_byte_sel.sv
module dlf_byte_sel
    import dlf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 9,
    parameter int AIDX_W = 2
) (
    input  fr_state_e         state,
    input  logic [7:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [AIDX_W-1:0] addr_idx,
    input  logic [7:0]        pl_byte,
    input  logic [7:0]        neg_sum,
    output logic [7:0]        byte_out
);
    localparam int ADDR_BYTES = ADDR_W / 8;

    logic [ADDR_W-1:0] addr_sh;
    logic [7:0]        count_b;

    assign addr_sh = addr << (32'(addr_idx) * 8);
    assign count_b = 8'(len + LEN_W'(ADDR_BYTES + 1));

    always_comb begin
        unique case (state)
            ST_SYNC0: byte_out = MARK_A;
            ST_SYNC1: byte_out = MARK_B;
            ST_COUNT: byte_out = count_b;
            ST_CMD:   byte_out = cmd;
            ST_ADDR:  byte_out = addr_sh[ADDR_W-1 -: 8];
            ST_DATA:  byte_out = (cmd == OP_VERIFY) ? swizzle(pl_byte) : pl_byte;
            ST_SUM:   byte_out = neg_sum;
            default:  byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/dl_pkt_framer.sv
module dl_pkt_framer
    import dlf_pkg::*;
#(
    parameter int MAX_PAYLOAD = 250,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(MAX_PAYLOAD),
    localparam int LEN_W      = $clog2(MAX_PAYLOAD + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_waddr,
    input  logic [7:0]        buf_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_restart,
    output logic              res_reject
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int AIDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    fr_state_e state_q, state_d;

    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [AIDX_W-1:0] addr_idx_q;
    logic [IDX_W-1:0]  data_idx_q;
    logic              pass_q, restart_q, reject_q;

    logic       accept, fire, refuse, addr_last, data_last, summing;
    logic [7:0] pl_byte, neg_sum;

    assign accept    = req_valid && req_ready;
    assign fire      = out_valid && out_ready;
    assign refuse    = (req_len > LEN_W'(MAX_PAYLOAD)) ||
                       ((req_cmd == OP_ERASE) && (req_len != LEN_W'(1)));
    assign addr_last = (addr_idx_q == AIDX_W'(ADDR_BYTES - 1));
    assign data_last = ((LEN_W'(data_idx_q) + LEN_W'(1)) == len_q);
    assign summing   = (state_q == ST_COUNT) || (state_q == ST_CMD) ||
                       (state_q == ST_ADDR)  || (state_q == ST_DATA);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = refuse ? ST_REPORT : ST_SYNC0;
            ST_SYNC0:  if (fire) state_d = ST_SYNC1;
            ST_SYNC1:  if (fire) state_d = ST_COUNT;
            ST_COUNT:  if (fire) state_d = ST_CMD;
            ST_CMD:    if (fire) state_d = ST_ADDR;
            ST_ADDR:   if (fire && addr_last)
                           state_d = (len_q == '0) ? ST_SUM : ST_DATA;
            ST_DATA:   if (fire && data_last) state_d = ST_SUM;
            ST_SUM:    if (fire) state_d = ST_WAIT;
            ST_WAIT:   if (rsp_valid) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture, byte counters and response outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            addr_idx_q <= '0;
            data_idx_q <= '0;
            pass_q     <= 1'b0;
            restart_q  <= 1'b0;
            reject_q   <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q      <= req_cmd;
                addr_q     <= req_addr;
                len_q      <= req_len;
                addr_idx_q <= '0;
                data_idx_q <= '0;
                pass_q     <= 1'b0;
                restart_q  <= 1'b0;
                reject_q   <= refuse;
            end
            if (fire && state_q == ST_ADDR) addr_idx_q <= addr_idx_q + AIDX_W'(1);
            if (fire && state_q == ST_DATA) data_idx_q <= data_idx_q + IDX_W'(1);
            if (state_q == ST_WAIT && rsp_valid) begin
                pass_q    <= (rsp_data == RSP_OK);
                restart_q <= (rsp_data != RSP_OK);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        out_valid   = 1'b0;
        res_valid   = 1'b0;
        res_pass    = 1'b0;
        res_restart = 1'b0;
        res_reject  = 1'b0;
        unique case (state_q)
            ST_SYNC0, ST_SYNC1, ST_COUNT, ST_CMD,
            ST_ADDR, ST_DATA, ST_SUM: out_valid = 1'b1;
            ST_REPORT: begin
                res_valid   = 1'b1;
                res_pass    = pass_q;
                res_restart = restart_q;
                res_reject  = reject_q;
            end
            default: ;
        endcase
    end

    dlf_payload_buf #(.DEPTH(MAX_PAYLOAD), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (data_idx_q),
        .rdata (pl_byte)
    );

    dlf_sum_acc u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .add_en   (fire && summing),
        .add_byte (out_data),
        .neg_sum  (neg_sum)
    );

    dlf_byte_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AIDX_W(AIDX_W)) u_sel (
        .state    (state_q),
        .cmd      (cmd_q),
        .addr     (addr_q),
        .len      (len_q),
        .addr_idx (addr_idx_q),
        .pl_byte  (pl_byte),
        .neg_sum  (neg_sum),
        .byte_out (out_data)
    );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
    parameter int MAX_PAYLOAD = 250,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [7:0]        req_cmd,
    input logic [LEN_W-1:0]  req_len,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              res_valid,
    input logic              res_pass,
    input logic              res_restart,
    input logic              res_reject
);
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r1_lead_marker: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == 8'h07));

    a_r7_long_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len > LEN_W'(MAX_PAYLOAD)))
        |=> (!out_valid && res_valid && res_reject));

    a_r6_erase_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_cmd == 8'h45) && (req_len != LEN_W'(1)))
        |=> (!out_valid && res_valid && res_reject));

    a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && out_valid));

    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_pass, res_restart, res_reject}) == 1));

    a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_pass || res_restart || res_reject));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind dl_pkt_framer dlf_checker #(
    .MAX_PAYLOAD(MAX_PAYLOAD), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_dlf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cmd     (req_cmd),
    .req_len     (req_len),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .res_valid   (res_valid),
    .res_pass    (res_pass),
    .res_restart (res_restart),
    .res_reject  (res_reject)
);

// File: tb/test_dl_pkt_framer.sv
module test_dl_pkt_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_we = 1'b0;
    logic [7:0]  buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        res_valid, res_pass, res_restart, res_reject;

    always #2 clk = ~clk;

    dl_pkt_framer i_dl_pkt_framer (
        .clk(clk), .rst_n(rst_n),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .res_valid(res_valid), .res_pass(res_pass),
        .res_restart(res_restart), .res_reject(res_reject)
    );

    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    int          stall_mode = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  pl[250];
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = '0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model: compares every transferred byte, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            case (stall_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 5) < 2;
            endcase
            if (prev_stall) begin
                chk(out_valid && (out_data == prev_data), "R8 stall hold",
                    {23'd0, out_valid, out_data}, {24'd1, prev_data});
            end
            if (out_valid && exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected byte", out_data, -1);
            end else if (out_valid && out_ready) begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(out_data == e, t, out_data, e);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic load(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pl[i]     = 8'(i * 37 + seed);
            buf_we    = 1'b1;
            buf_waddr = 8'(i);
            buf_wdata = pl[i];
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    // build expected stream (R1..R4) and hand over the request
    task automatic send(input logic [7:0] cmd, input logic [31:0] addr,
                        input int len, input bit expect_tx, input string sum_tag);
        if (expect_tx) begin
            automatic logic [7:0] s;
            automatic logic [7:0] cnt = 8'(len + 5);
            push(8'h07, "R1 marker0");
            push(8'h0E, "R1 marker1");
            push(cnt, "R2 count");
            push(cmd, "R1 opcode");
            s = cnt + cmd;
            for (int k = 3; k >= 0; k--) begin
                push(addr[k*8 +: 8], "R1 address");
                s = s + addr[k*8 +: 8];
            end
            for (int i = 0; i < len; i++) begin
                automatic logic [7:0] b = pl[i];
                if (cmd == 8'h56) b = {pl[i][4:0], pl[i][7:5]};
                push(b, (cmd == 8'h56) ? "R4 verify payload" : "R4 plain payload");
                s = s + b;
            end
            push(8'(256 - int'(s)), sum_tag);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = addr;
        req_len   = 9'(len);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic respond(input logic [7:0] r, input bit e_pass);
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(!res_valid && !req_ready, "R9 waits for response",
            {res_valid, req_ready}, 0);
        rsp_valid = 1'b1;
        rsp_data  = r;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(res_valid && (res_pass == e_pass) && (res_restart == !e_pass) && !res_reject,
            "R9 result", {res_valid, res_pass, res_restart, res_reject},
            {1'b1, e_pass, !e_pass, 1'b0});
        @(negedge clk);
        chk(!res_valid && req_ready, "R10 one-cycle result then idle",
            {res_valid, req_ready}, 1);
    endtask

    task automatic expect_reject(input string t);
        chk(res_valid && res_reject && !res_pass && !res_restart && !out_valid, t,
            {res_valid, res_reject, res_pass, res_restart, out_valid}, 5'b11000);
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid && req_ready, t, {out_valid, req_ready}, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !res_valid, "R10 reset outputs", {out_valid, res_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !out_valid, "R10 idle ready", {req_ready, out_valid}, 2);

        // R5 run / software reset
        stall_mode = 0;
        send(8'h52, 32'h0000_0001, 0, 1'b1, "R5 run checksum 0xA8");
        respond(8'h06, 1'b1);

        // write, short, no stalls
        load(4, 11);
        send(8'h57, 32'h0008_1230, 4, 1'b1, "R3 checksum write");
        respond(8'h06, 1'b1);

        // write with stalls, BEL response
        stall_mode = 1;
        load(16, 90);
        send(8'h57, 32'hDEAD_BEEF, 16, 1'b1, "R3 checksum stalled write");
        respond(8'h07, 1'b0);

        // verify rotation
        stall_mode = 2;
        send(8'h56, 32'h0008_1240, 16, 1'b1, "R3 checksum verify");
        respond(8'h55, 1'b0);

        // erase, one page-count byte
        stall_mode = 0;
        load(1, 16);
        send(8'h45, 32'h0008_0200, 1, 1'b1, "R3 checksum erase");
        respond(8'h06, 1'b1);

        // malformed erase and oversize requests refused
        send(8'h45, 32'h0008_0200, 2, 1'b0, "");
        expect_reject("R6 erase length refused");
        send(8'h45, 32'h0, 0, 1'b0, "");
        expect_reject("R6 empty erase refused");
        send(8'h57, 32'h0008_0000, 251, 1'b0, "");
        expect_reject("R7 length 251 refused");

        // maximum payload
        stall_mode = 1;
        load(250, 3);
        send(8'h57, 32'h0009_0000, 250, 1'b1, "R3 checksum max write");
        respond(8'h06, 1'b1);
        stall_mode = 2;
        send(8'h56, 32'h0009_0000, 250, 1'b1, "R7 max verify checksum");
        respond(8'h06, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule